// File: doc/BRIEF.md
# DMA Ring Pointer Controller

This block tracks a circular command ring in memory for an asynchronous DMA engine. Software programs a small register bank: ring control, a 256-byte-aligned ring base, the read and write pointers, a split read-pointer writeback address and an indirect-buffer control bit. While the ring is enabled and the read index has not caught up with the write index, the block requests dword fetches at `base*256 + readIndex*4`. Each accepted fetch advances the read index, which wraps at the programmed ring length.

When the engine marks a fetched dword as the last one of a command packet and writeback is enabled, the block posts a single memory-write request. That request carries the new read pointer in byte form to the programmed writeback address and stays up until the memory side acknowledges it. Clearing the enable bit freezes fetching and leaves both pointers untouched. An idle flag shows that an enabled ring has drained.

Top module: `dma_ring_ptr_ctrl`

## Requirements
- R1: After reset every register reads zero, and `fetchReq`, `wbReq`, `ibEnable` and `idle` are low. Register offsets on `regAddr`: 0 control, 1 base, 2 read pointer, 3 write pointer, 4 writeback low, 5 writeback high, 6 indirect-buffer control. Offset 7 reads zero.
- R2: A write to the read or write pointer keeps only bits 17:2 as the dword index. A read returns that index shifted left by 2, so bits 1:0 and 31:18 read as zero.
- R3: `fetchReq` is high exactly when control bit 0 (enable) is set and the read index differs from the write index. `fetchAddr` equals the base register times 256 plus the read index times 4.
- R4: A cycle with `fetchReq` and `fetchAck` both high advances the read index by one modulo 2^N. N is the control field in bits 5:1, and a value above 16 acts as 16.
- R5: While enable is clear, no fetch is requested and the read index does not change, whatever `fetchAck` does.
- R6: `idle` is high exactly when enable is set and the read index equals the write index.
- R7: When an accepted fetch has `fetchLast` high and control bit 6 (writeback enable) is set, `wbReq` is high from the next cycle with `wbData` equal to the advanced read pointer in byte form. It holds until a cycle with `wbAck`. With bit 6 clear, no writeback is posted.
- R8: Writeback low reads back with bits 1:0 zero, and writeback high keeps only its low 8 bits. `wbAddr` is {high[7:0], low[31:2], 2'b00}.
- R9: `ibEnable` follows bit 0 of the indirect-buffer control register.
- R10: A software write to the read pointer in the same cycle as an accepted fetch takes precedence over the advance. A newer packet completion while a writeback is still pending replaces `wbData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for write and read |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the register at `regAddr` |
| fetchReq | output | 1 | Dword fetch request |
| fetchAddr | output | 40 | Byte address of the dword to fetch |
| fetchAck | input | 1 | Fetch accepted; dword consumed |
| fetchLast | input | 1 | Consumed dword closes a packet |
| wbReq | output | 1 | Read-pointer writeback request |
| wbAddr | output | 40 | Writeback byte address |
| wbData | output | 32 | Read pointer in byte form |
| wbAck | input | 1 | Writeback accepted |
| ibEnable | output | 1 | Indirect buffers allowed |
| idle | output | 1 | Enabled ring has drained |

## Verification
The bound checker watches the per-cycle rules on every cycle. An accepted fetch must step the read index by one under the ring mask, and the index must stay put when no fetch is accepted and software does not write it. A pending writeback must hold its request and its data, idle and a fetch request must never coincide, and pointer readback must keep its low bits clear. Some behaviour only the bench scenarios can show: the actual wrap point for a given size field, the clamp of oversized fields, the pointer freeze across a disable, the last-writer-wins case of a software write racing an advance, and data replacement under a stalled writeback. The bench shows these by comparing against its reference model and by reading the pointers back.

// File: rtl/ringctl_pkg.sv
package ringctl_pkg;

  // register offsets decoded on regAddr
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_BASE  = 3'd1,
    REG_RPTR  = 3'd2,
    REG_WPTR  = 3'd3,
    REG_WBLO  = 3'd4,
    REG_WBHI  = 3'd5,
    REG_IBCTL = 3'd6
  } regSel_e;

  // ring control field layout
  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_SZ_LSB = 1;
  localparam int unsigned CTRL_SZ_W   = 5;
  localparam int unsigned CTRL_WB_BIT = CTRL_SZ_LSB + CTRL_SZ_W;
  localparam int unsigned CTRL_W      = CTRL_WB_BIT + 1;

  // dword index sits above the two byte-offset bits
  localparam int unsigned PTR_LSB = 2;

  // control -> datapath strobes
  typedef struct packed {
    logic wrCtrl;
    logic wrBase;
    logic wrRptr;
    logic wrWptr;
    logic wrWbLo;
    logic wrWbHi;
    logic wrIb;
    logic advance;
    logic loadWb;
    logic clearWb;
  } strobes_t;

  // datapath -> control status
  typedef struct packed {
    logic ringEn;
    logic wbEn;
    logic ptrEqual;
    logic wbPending;
  } status_t;

endpackage

// File: rtl/ringctl_control.sv
module ringctl_control
  import ringctl_pkg::*;
(
  input  logic       regWe,
  input  logic [2:0] regAddr,
  input  logic       fetchAck,
  input  logic       fetchLast,
  input  logic       wbAck,
  input  status_t    stat,
  output strobes_t   stb,
  output logic       fetchReq,
  output logic       wbReq,
  output logic       idle
);

  logic fetchGo;

  assign fetchReq = stat.ringEn & ~stat.ptrEqual;
  assign idle     = stat.ringEn &  stat.ptrEqual;
  assign wbReq    = stat.wbPending;
  assign fetchGo  = fetchReq & fetchAck;

  always_comb begin
    stb         = '0;
    stb.advance = fetchGo;
    stb.loadWb  = fetchGo & fetchLast & stat.wbEn;
    stb.clearWb = stat.wbPending & wbAck;
    if (regWe) begin
      case (regAddr)
        REG_CTRL:  stb.wrCtrl = 1'b1;
        REG_BASE:  stb.wrBase = 1'b1;
        REG_RPTR:  stb.wrRptr = 1'b1;
        REG_WPTR:  stb.wrWptr = 1'b1;
        REG_WBLO:  stb.wrWbLo = 1'b1;
        REG_WBHI:  stb.wrWbHi = 1'b1;
        REG_IBCTL: stb.wrIb   = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/ringctl_datapath.sv
module ringctl_datapath
  import ringctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EXT_W  = 8,
  parameter int unsigned IDX_W  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobes_t                     stb,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [2:0]                   rdSel,
  output logic [DATA_W-1:0]            rdata,
  output status_t                      stat,
  output logic [DATA_W+EXT_W-1:0]      fetchAddr,
  output logic [DATA_W+EXT_W-1:0]      wbAddr,
  output logic [DATA_W-1:0]            wbData,
  output logic                         ibEnable,
  output logic [IDX_W-1:0]             rdIdxO,
  output logic [IDX_W-1:0]             ringMaskO
);

  localparam int unsigned ADDR_W  = DATA_W + EXT_W;
  localparam int unsigned PTR_MSB = PTR_LSB + IDX_W - 1;
  localparam int unsigned PAD_D   = DATA_W - IDX_W - PTR_LSB;
  localparam int unsigned PAD_A   = ADDR_W - IDX_W - PTR_LSB;

  logic [CTRL_W-1:0]         ctrlReg;
  logic [DATA_W-1:0]         baseReg;
  logic [IDX_W-1:0]          rdIdx;
  logic [IDX_W-1:0]          wrIdx;
  logic [DATA_W-1:PTR_LSB]   wbLoReg;
  logic [EXT_W-1:0]          wbHiReg;
  logic                      ibReg;
  logic                      wbPendReg;
  logic [DATA_W-1:0]         wbDataReg;

  logic [CTRL_SZ_W-1:0]      sizeField;
  logic [IDX_W-1:0]          ringMask;
  logic [IDX_W-1:0]          rdNext;

  function automatic logic [DATA_W-1:0] idxToBytes(input logic [IDX_W-1:0] idx);
    return {{PAD_D{1'b0}}, idx, {PTR_LSB{1'b0}}};
  endfunction

  assign sizeField = ctrlReg[CTRL_SZ_LSB +: CTRL_SZ_W];

  // bit i of the mask is set when i < log2 size; fields above IDX_W saturate
  always_comb begin
    for (int i = 0; i < IDX_W; i++) begin
      ringMask[i] = (int'(sizeField) > i);
    end
  end

  assign rdNext = (rdIdx + 1'b1) & ringMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      baseReg <= '0;
      wrIdx   <= '0;
      wbLoReg <= '0;
      wbHiReg <= '0;
      ibReg   <= 1'b0;
    end else begin
      if (stb.wrCtrl) ctrlReg <= wdata[CTRL_W-1:0];
      if (stb.wrBase) baseReg <= wdata;
      if (stb.wrWptr) wrIdx   <= wdata[PTR_MSB:PTR_LSB];
      if (stb.wrWbLo) wbLoReg <= wdata[DATA_W-1:PTR_LSB];
      if (stb.wrWbHi) wbHiReg <= wdata[EXT_W-1:0];
      if (stb.wrIb)   ibReg   <= wdata[0];
    end
  end

  // software write wins over a same-cycle advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx <= '0;
    end else if (stb.wrRptr) begin
      rdIdx <= wdata[PTR_MSB:PTR_LSB];
    end else if (stb.advance) begin
      rdIdx <= rdNext;
    end
  end

  // a newer completion overrides an unacknowledged writeback
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbPendReg <= 1'b0;
      wbDataReg <= '0;
    end else if (stb.loadWb) begin
      wbPendReg <= 1'b1;
      wbDataReg <= idxToBytes(rdNext);
    end else if (stb.clearWb) begin
      wbPendReg <= 1'b0;
    end
  end

  always_comb begin
    case (rdSel)
      REG_CTRL:  rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrlReg};
      REG_BASE:  rdata = baseReg;
      REG_RPTR:  rdata = idxToBytes(rdIdx);
      REG_WPTR:  rdata = idxToBytes(wrIdx);
      REG_WBLO:  rdata = {wbLoReg, {PTR_LSB{1'b0}}};
      REG_WBHI:  rdata = {{(DATA_W-EXT_W){1'b0}}, wbHiReg};
      REG_IBCTL: rdata = {{(DATA_W-1){1'b0}}, ibReg};
      default:   rdata = '0;
    endcase
  end

  assign stat.ringEn    = ctrlReg[CTRL_EN_BIT];
  assign stat.wbEn      = ctrlReg[CTRL_WB_BIT];
  assign stat.ptrEqual  = (rdIdx == wrIdx);
  assign stat.wbPending = wbPendReg;

  assign fetchAddr = {baseReg, {EXT_W{1'b0}}} + {{PAD_A{1'b0}}, rdIdx, {PTR_LSB{1'b0}}};
  assign wbAddr    = {wbHiReg, wbLoReg, {PTR_LSB{1'b0}}};
  assign wbData    = wbDataReg;
  assign ibEnable  = ibReg;
  assign rdIdxO    = rdIdx;
  assign ringMaskO = ringMask;

endmodule

// File: rtl/dma_ring_ptr_ctrl.sv
module dma_ring_ptr_ctrl
  import ringctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EXT_W  = 8,
  parameter int unsigned IDX_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [2:0]              regAddr,
  input  logic [DATA_W-1:0]       regWdata,
  output logic [DATA_W-1:0]       regRdata,
  output logic                    fetchReq,
  output logic [DATA_W+EXT_W-1:0] fetchAddr,
  input  logic                    fetchAck,
  input  logic                    fetchLast,
  output logic                    wbReq,
  output logic [DATA_W+EXT_W-1:0] wbAddr,
  output logic [DATA_W-1:0]       wbData,
  input  logic                    wbAck,
  output logic                    ibEnable,
  output logic                    idle
);

  strobes_t          stb;
  status_t           stat;
  logic [IDX_W-1:0]  rdIdx;
  logic [IDX_W-1:0]  ringMask;

  ringctl_control u_ctl (
    .regWe     (regWe),
    .regAddr   (regAddr),
    .fetchAck  (fetchAck),
    .fetchLast (fetchLast),
    .wbAck     (wbAck),
    .stat      (stat),
    .stb       (stb),
    .fetchReq  (fetchReq),
    .wbReq     (wbReq),
    .idle      (idle)
  );

  ringctl_datapath #(
    .DATA_W (DATA_W),
    .EXT_W  (EXT_W),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wdata     (regWdata),
    .rdSel     (regAddr),
    .rdata     (regRdata),
    .stat      (stat),
    .fetchAddr (fetchAddr),
    .wbAddr    (wbAddr),
    .wbData    (wbData),
    .ibEnable  (ibEnable),
    .rdIdxO    (rdIdx),
    .ringMaskO (ringMask)
  );

endmodule

// File: rtl/dma_ring_ptr_ctrl_chk.sv
module dma_ring_ptr_ctrl_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [2:0]        regAddr,
  input logic [DATA_W-1:0] regRdata,
  input logic              fetchReq,
  input logic              fetchAck,
  input logic              fetchLast,
  input logic              wbReq,
  input logic              wbAck,
  input logic [DATA_W-1:0] wbData,
  input logic              idle,
  input logic [IDX_W-1:0]  rdIdx,
  input logic [IDX_W-1:0]  ringMask
);

  logic swRptr;
  assign swRptr = regWe && (regAddr == 3'd2);

  // R4
  advance_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchAck && !swRptr) |=> (rdIdx == (($past(rdIdx) + 1'b1) & $past(ringMask))));

  // R5
  index_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(fetchReq && fetchAck) && !swRptr) |=> $stable(rdIdx));

  // R6
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !fetchReq);

  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> wbReq);

  // R7
  wb_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck && !(fetchReq && fetchAck && fetchLast)) |=> $stable(wbData));

  // R2
  ptr_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd2 || regAddr == 3'd3) |-> (regRdata[1:0] == 2'b00 && regRdata[DATA_W-1:IDX_W+2] == '0));

endmodule

bind dma_ring_ptr_ctrl dma_ring_ptr_ctrl_chk #(
  .DATA_W (DATA_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWe     (regWe),
  .regAddr   (regAddr),
  .regRdata  (regRdata),
  .fetchReq  (fetchReq),
  .fetchAck  (fetchAck),
  .fetchLast (fetchLast),
  .wbReq     (wbReq),
  .wbAck     (wbAck),
  .wbData    (wbData),
  .idle      (idle),
  .rdIdx     (rdIdx),
  .ringMask  (ringMask)
);

// File: tb/dma_ring_ptr_ctrl_bench.sv
`timescale 1ns/1ps
module dma_ring_ptr_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        fetchReq;
  logic [39:0] fetchAddr;
  logic        fetchAck = 1'b0;
  logic        fetchLast = 1'b0;
  logic        wbReq;
  logic [39:0] wbAddr;
  logic [31:0] wbData;
  logic        wbAck = 1'b0;
  logic        ibEnable;
  logic        idle;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int fMode  = 0;   // 0 no ack, 1 always, 2 pattern
  int wMode  = 0;   // 0 no ack, 1 always
  bit done   = 1'b0;

  // reference model state
  logic [6:0]  mCtrl;
  logic [31:0] mBase;
  logic [15:0] mRd, mWr;
  logic [31:0] mWbLo;
  logic [7:0]  mWbHi;
  logic        mIb, mPend;
  logic [31:0] mWbData;

  always #2.5 clk = ~clk;

  dma_ring_ptr_ctrl u_dma_ring_ptr_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchAck(fetchAck),
    .fetchLast(fetchLast), .wbReq(wbReq), .wbAddr(wbAddr), .wbData(wbData), .wbAck(wbAck),
    .ibEnable(ibEnable), .idle(idle)
  );

  function automatic logic [15:0] modelMask(input logic [4:0] sz);
    int m;
    if (sz >= 16) m = 32'hFFFF; else m = (1 << sz) - 1;
    return m[15:0];
  endfunction

  task automatic check(input string req, input string what, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // model update, behavioural
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl = '0; mBase = '0; mRd = '0; mWr = '0; mWbLo = '0; mWbHi = '0;
      mIb = 1'b0; mPend = 1'b0; mWbData = '0;
    end else begin
      logic go;
      logic [15:0] nxt;
      go  = mCtrl[0] && (mRd != mWr) && fetchAck;
      nxt = (mRd + 16'd1) & modelMask(mCtrl[5:1]);
      if (go && fetchLast && mCtrl[6]) begin
        mPend = 1'b1; mWbData = {14'd0, nxt, 2'b00};
      end else if (mPend && wbAck) begin
        mPend = 1'b0;
      end
      if (go) mRd = nxt;
      if (regWe) begin
        case (regAddr)
          3'd0: mCtrl = regWdata[6:0];
          3'd1: mBase = regWdata;
          3'd2: mRd   = regWdata[17:2];
          3'd3: mWr   = regWdata[17:2];
          3'd4: mWbLo = regWdata & 32'hFFFF_FFFC;
          3'd5: mWbHi = regWdata[7:0];
          3'd6: mIb   = regWdata[0];
          default: ;
        endcase
      end
    end
  end

  // handshake drivers
  always @(posedge clk) begin
    #1;
    cyc++;
    fetchAck  = (fMode == 1) || (fMode == 2 && (cyc % 3) != 0);
    fetchLast = (cyc % 2) == 0;
    wbAck     = (wMode == 1);
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3", "fetchReq", 40'(fetchReq), 40'(mCtrl[0] && (mRd != mWr)));
      check("R3", "fetchAddr", fetchAddr, {mBase, 8'h00} + {22'd0, mRd, 2'b00});
      check("R6", "idle", 40'(idle), 40'(mCtrl[0] && (mRd == mWr)));
      check("R7", "wbReq", 40'(wbReq), 40'(mPend));
      check("R7", "wbData", 40'(wbData), 40'(mWbData));
      check("R8", "wbAddr", wbAddr, {mWbHi, mWbLo});
      check("R9", "ibEnable", 40'(ibEnable), 40'(mIb));
    end
  end

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic readCheck(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    regAddr = a;
    @(negedge clk);
    check(req, $sformatf("reg%0d", a), 40'(regRdata), 40'(exp));
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    for (int a = 0; a < 8; a++) readCheck(3'(a), 32'd0, "R1");
    check("R1", "fetchReq", 40'(fetchReq), 40'd0);
    check("R1", "idle", 40'(idle), 40'd0);
    check("R1", "wbReq", 40'(wbReq), 40'd0);

    // R8: writeback address registers
    writeReg(3'd4, 32'hABCDE0F3);
    readCheck(3'd4, 32'hABCDE0F0, "R8");
    writeReg(3'd5, 32'h0000_01FF);
    readCheck(3'd5, 32'h0000_00FF, "R8");
    writeReg(3'd1, 32'h0012_3456);
    // R9
    writeReg(3'd6, 32'h1);
    check("R9", "ibEnable on", 40'(ibEnable), 40'd1);
    writeReg(3'd2, 32'h0);
    writeReg(3'd3, 32'h0);
    // enable, 8-dword ring, writeback on
    writeReg(3'd0, 32'h47);
    check("R6", "idle empty ring", 40'(idle), 40'd1);
    wMode = 1;

    // R2: write pointer low bits ignored
    writeReg(3'd3, 32'h17);
    readCheck(3'd3, 32'h14, "R2");
    fMode = 1;
    run(10);
    readCheck(3'd2, 32'h14, "R2");
    check("R6", "idle drained", 40'(idle), 40'd1);

    // R4: wrap in an 8-dword ring
    writeReg(3'd3, 32'h8);
    fMode = 2;
    run(20);
    readCheck(3'd2, 32'h8, "R4");

    // R5: disabled ring keeps pointers
    writeReg(3'd0, 32'h46);
    writeReg(3'd3, 32'h18);
    fMode = 1;
    run(10);
    readCheck(3'd2, 32'h8, "R5");
    check("R5", "fetchReq off", 40'(fetchReq), 40'd0);
    check("R5", "idle off", 40'(idle), 40'd0);

    // R7: writeback disabled
    run(3);
    writeReg(3'd0, 32'h07);
    run(10);
    readCheck(3'd2, 32'h18, "R7");
    check("R7", "no writeback", 40'(wbReq), 40'd0);

    // R10: stalled writeback gets newer data
    wMode = 0;
    writeReg(3'd0, 32'h47);
    writeReg(3'd3, 32'h0C);
    run(12);
    check("R10", "wbReq held", 40'(wbReq), 40'd1);
    check("R10", "latest data", 40'(wbData), 40'(mWbData));
    wMode = 1;
    run(3);

    // R4: oversize field clamps to 16 bits
    fMode = 0;
    writeReg(3'd0, 32'h29);
    writeReg(3'd2, 32'h3FFFC);
    writeReg(3'd3, 32'h4);
    fMode = 1;
    run(6);
    readCheck(3'd2, 32'h4, "R4");

    // R10: software write wins over an advance
    writeReg(3'd3, 32'h100);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = 3'd2; regWdata = 32'h40;
    @(posedge clk); #1;
    regWe = 1'b0;
    @(negedge clk);
    check("R10", "sw write wins", 40'(regRdata), 40'h40);
    run(70);
    readCheck(3'd2, 32'h100, "R4");
    finishRun();
  end

endmodule